// File: doc/BRIEF.md
# Start-Triggered Count-and-Flag Sequencer

This block pairs a three-state controller with a small datapath. It waits in an idle phase until a start pin is high at a clock edge. On that edge it clears a 4-bit count and a done flag and enters a counting phase. In the counting phase the count rises by one on every clock. A tracking flag copies bit 1 of the count as that bit stood before the increment. When bits 1 and 2 of the count are both 1 before the increment, the controller moves to a one-cycle finishing phase. That phase raises the done flag and returns the controller to idle.

Every register transfer that belongs to a phase happens on a single clock edge. All branch decisions in that phase use the register values from before that edge. From a cleared count, a run therefore visits counts 1 through 7 and leaves counting on the edge that takes the count from 6 to 7. The phase is held in a two-bit code: idle = 00, counting = 01, finishing = 11. Code 10 is unused and returns to idle on the next clock. Three decoded strobes show the current phase. All pins are plain level signals with no handshake.

Top module: `asm_count_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in idle (strobe idle_o = 1) and clears count_o, track_o and done_o to 0.
- R2: In idle with start_i = 0, the sequencer stays idle, and count_o, track_o and done_o keep their values.
- R3: In idle with start_i = 1, the next edge clears count_o and done_o to 0 and enters counting. track_o is left unchanged.
- R4: On every edge taken in counting, count_o increments by 1 modulo 16.
- R5: On an edge taken in counting, track_o takes the value of count_o bit 1 (weight 2) from before that edge. In the other phases track_o keeps its value.
- R6: A counting edge moves to finishing when count_o bits 1 and 2 (weights 2 and 4) were both 1 before the edge. Otherwise the sequencer stays in counting.
- R7: The edge taken in finishing sets done_o to 1 and returns to idle unconditionally. start_i is ignored in that phase.
- R8: Exactly one of idle_o, count_ph_o and fin_o is high after reset. Their order of encoding is 00, 01 and 11.
- R9: A run started from idle spends exactly 7 cycles in counting and reaches finishing with count_o = 7 and track_o = 1. done_o reads 1 in the idle cycle that follows.
- R10: start_i has no effect while counting. count_o keeps incrementing, and the run length stays 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled in idle |
| count_o | output | 4 | Count register |
| track_o | output | 1 | Tracking flag (pre-increment count bit 1) |
| done_o | output | 1 | Done flag, set in finishing |
| idle_o | output | 1 | Idle phase strobe |
| count_ph_o | output | 1 | Counting phase strobe |
| fin_o | output | 1 | Finishing phase strobe |

## Verification
A wrong phase code shows on the strobes in the same cycle. A wrong code also shows one clock later in count_o, which increments or freezes wrongly, or in done_o, which rises early or never. An error in the branch or in the tracking flag shows within one edge as an off-by-one run length or a wrong track_o value. The bench therefore compares every output against an arithmetic model on every cycle. It sweeps start patterns from single pulses to a start held high permanently, with varied idle gaps, and includes a reset in the middle of a run.

// File: rtl/asm_count_pkg.sv
package asm_count_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_COUNT = 2'b01,
    PH_SPARE = 2'b10,
    PH_FIN   = 2'b11
  } phase_e;
endpackage

// File: rtl/asm_seq_ctl.sv
module asm_seq_ctl
  import asm_count_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cond_lo_i,
  input  logic cond_hi_i,
  output logic idle_o,
  output logic count_o,
  output logic fin_o
);
  localparam int NCODE = 4;

  phase_e ph_q;
  logic   g1_d, g0_d;
  logic [NCODE-1:0] dec;

  // 2-to-4 decode of the phase code
  for (genvar i = 0; i < NCODE; i++) begin : g_dec
    assign dec[i] = (ph_q == phase_e'(i));
  end

  assign idle_o  = dec[PH_IDLE];
  assign count_o = dec[PH_COUNT];
  assign fin_o   = dec[PH_FIN];

  // next-state equations; unused code 10 yields 00
  assign g1_d = count_o & cond_lo_i & cond_hi_i;
  assign g0_d = (idle_o & start_i) | count_o;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_IDLE;
    else     ph_q <= phase_e'({g1_d, g0_d});
  end

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({idle_o, count_o, fin_o}));
  // R6
  fin_entry_chk: assert property (@(posedge clk) disable iff (rst)
    count_o && cond_lo_i && cond_hi_i |=> fin_o);
  // R7
  fin_exit_chk: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> idle_o);
endmodule

// File: rtl/asm_count_dp.sv
module asm_count_dp #(
  parameter int CNT_W  = 4,
  parameter int BIT_LO = 1,
  parameter int BIT_HI = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             setf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trk_o,
  output logic             done_o,
  output logic             cond_lo_o,
  output logic             cond_hi_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             trk_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      trk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (clr_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end
      if (inc_i) begin
        cnt_q <= cnt_q + ONE;
        trk_q <= cnt_q[BIT_LO];
      end
      if (setf_i) done_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign trk_o     = trk_q;
  assign done_o    = done_q;
  assign cond_lo_o = cnt_q[BIT_LO];
  assign cond_hi_o = cnt_q[BIT_HI];

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0) && !done_o);
  // R4
  incr_chk: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> cnt_o == $past(cnt_o) + ONE);
  // R5
  track_chk: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> trk_o == $past(cnt_o[BIT_LO]));
  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    setf_i |=> done_o);
endmodule

// File: rtl/asm_count_seq.sv
module asm_count_seq #(
  parameter int CNT_W  = 4,
  parameter int BIT_LO = 1,
  parameter int BIT_HI = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic [CNT_W-1:0] count_o,
  output logic             track_o,
  output logic             done_o,
  output logic             idle_o,
  output logic             count_ph_o,
  output logic             fin_o
);
  logic c_lo, c_hi;

  asm_seq_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .cond_lo_i (c_lo),
    .cond_hi_i (c_hi),
    .idle_o    (idle_o),
    .count_o   (count_ph_o),
    .fin_o     (fin_o)
  );

  asm_count_dp #(.CNT_W(CNT_W), .BIT_LO(BIT_LO), .BIT_HI(BIT_HI)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (idle_o & start_i),
    .inc_i     (count_ph_o),
    .setf_i    (fin_o),
    .cnt_o     (count_o),
    .trk_o     (track_o),
    .done_o    (done_o),
    .cond_lo_o (c_lo),
    .cond_hi_o (c_hi)
  );

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    idle_o && !start_i |=> idle_o && $stable(count_o) && $stable(done_o) && $stable(track_o));
endmodule

// File: tb/asm_count_seq_tb.sv
module asm_count_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] cnt;
  logic trk, dn, ph0, ph1, ph2;

  int n_chk = 0, n_bad = 0, run = 0;
  bit finished = 0;
  int mst = 0;
  logic [3:0] ma = '0;
  logic me = 1'b0, mf = 1'b0;

  always #10 clk = ~clk;

  asm_count_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start), .count_o(cnt), .track_o(trk),
    .done_o(dn), .idle_o(ph0), .count_ph_o(ph1), .fin_o(ph2)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit s);
    int pst;
    bit prst;
    string tg;
    start = s;
    prst = rst;
    pst = mst;
    @(posedge clk);
    if (prst) begin
      mst = 0; ma = '0; me = 0; mf = 0;
    end else begin
      case (mst)
        0: if (s) begin ma = '0; mf = 0; mst = 1; end
        1: begin
             mst = (ma[1] && ma[2]) ? 2 : 1;
             me = ma[1];
             ma = ma + 4'd1;
           end
        default: begin mf = 1; mst = 0; end
      endcase
    end
    @(negedge clk);
    if (prst) tg = "R1";
    else if (pst == 0) tg = s ? "R3" : "R2";
    else if (pst == 1) tg = s ? "R10" : "R4";
    else tg = "R7";
    chk(tg, cnt, ma);
    chk(pst == 1 ? "R5" : tg, trk, me);
    chk(pst == 2 ? "R7" : tg, dn, mf);
    chk(pst == 1 ? "R6" : "R8", {ph2, ph1, ph0}, mst == 0 ? 1 : mst == 1 ? 2 : 4);
    if (ph1) run++;
    else if (ph2) begin
      chk("R9", run, 7);
      chk("R9", cnt, 7);
      chk("R9", trk, 1);
      run = 0;
    end else begin
      if (run == 0 && pst == 2 && !prst) chk("R9", dn, 1);
      run = 0;
    end
  endtask

  task automatic pat(int hi, int lo, int reps);
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k < hi; k++) step(1'b1);
      for (int k = 0; k < lo; k++) step(1'b0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(1'b0);
    step(1'b0);
    rst = 1'b0;
    // R1 reset state at ports
    chk("R1", {ph2, ph1, ph0, dn, trk, cnt}, 9'b001_0_0_0000);
    for (int k = 0; k < 3; k++) step(1'b0);
    for (int hi = 1; hi <= 12; hi++)
      for (int lo = 0; lo <= 10; lo++)
        pat(hi, lo, 3);
    pat(40, 0, 1);
    // reset in mid-run
    pat(1, 3, 1);
    rst = 1'b1;
    step(1'b0);
    rst = 1'b0;
    pat(1, 12, 2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule